// File: doc/BRIEF.md
# Multiplexed-DRAM to Asynchronous-SRAM Strobe Bridge

This block lets a host memory controller that drives a multiplexed DRAM interface use a 256K x 16 asynchronous SRAM instead. The host shares one 9-bit address bus between the row and column halves of each access. It marks the row half with an active-low row strobe for the expansion bank. It marks the column half with two active-low column strobes, one per byte lane. An active-low write enable gives the direction. The bridge rebuilds the 18-bit SRAM address from the two halves and drives the SRAM chip, output, write and byte enables.

Every host input is sampled by a fast local clock, at least 100 MHz, through two-flop synchronizers. The address bus passes through a pipeline of the same depth, so each address sample lines up with the strobe sample taken at the same instant. The SRAM is selected only after two things have happened: the row strobe is low, and a column strobe has fallen. A programmable number of local cycles must then pass so that the captured address settles first. A refresh cycle that pulses the row strobe alone therefore never selects the SRAM. All controls are released once the row strobe rises, and the cycle state clears with them.

The host must hold the row half of the address for at least one local clock period after the row strobe falls. It must also have the column half stable when a column strobe falls.

Top module: `dram_sram_bridge`

## Requirements
- R1: After reset, sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n and sram_lb_n are all high, and sram_addr is zero.
- R2: The bus value present when the row strobe falls is captured into sram_addr[17:9].
- R3: The bus value present at the first falling column strobe of a cycle is captured into sram_addr[8:0]. While chip enable stays active, later changes on the bus do not alter sram_addr.
- R4: A row strobe pulse with no column strobe (RAS-only refresh) never drives sram_ce_n low.
- R5: sram_ce_n goes low only after the row strobe is low and a column strobe has fallen. It goes low exactly SETTLE_CYC local cycles after the column is captured, which is the fifth local edge after the column strobe falls when the defaults are used.
- R6: While chip enable is active, sram_ub_n is low exactly when the upper column strobe is low, and sram_lb_n is low exactly when the lower one is low. Both low means a 16-bit word access. One low means a byte access on that lane only.
- R7: If we_n is high when the row strobe falls, the cycle is a read: sram_oe_n is low while chip enable is active, and sram_we_n stays high.
- R8: If we_n is low when the row strobe falls, the cycle is a write: sram_we_n is low while chip enable is active, and sram_oe_n stays high. The two are never low together.
- R9: Within three local cycles of the row strobe rising, all five SRAM controls are high again.
- R10: A column strobe that falls while the row strobe is high drives no SRAM control low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, at least 100 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Expansion-bank row strobe, active low |
| cas_hi_n | input | 1 | Upper-byte column strobe, active low |
| cas_lo_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Host write enable, active low |
| mux_addr | input | 9 | Shared row/column address bus |
| sram_addr | output | 18 | SRAM address: row high, column low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ub_n | output | 1 | SRAM upper byte enable, active low |
| sram_lb_n | output | 1 | SRAM lower byte enable, active low |

## Verification
Some properties hold on every cycle, and the bound checker tests those. Output enable and write enable are never low together, and each is only low under chip enable. Byte enables likewise only assert under chip enable. Chip enable never asserts unless a column strobe has been seen since the row strobe was last high. The controls are released within three cycles of the row strobe rising. The address holds steady while the SRAM is selected. Other behaviour can only be shown by the bench's scenarios. These cover the exact edge at which chip enable asserts after the settle count, the row and column values landing in the right halves of the address, and the mapping from strobe pattern to byte lane and direction. They also cover refresh pulses and stray column strobes leaving every control idle.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ROW    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_ACTIVE = 2'd3
  } cyc_state_e;

  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
    logic ub;
    logic lb;
  } sram_ctl_t;

endpackage

// File: rtl/dsb_sync.sv
module dsb_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_nx;

      always_comb begin
        sh_nx = {sh_q[STAGES-2:0], d[b]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL[b]}};
        else        sh_q <= sh_nx;
      end

      assign q[b] = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dsb_addr_latch.sv
module dsb_addr_latch #(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_en,
  input  logic              col_en,
  input  logic [HALF_W-1:0] bus,
  output logic [FULL_W-1:0] addr
);

  logic [HALF_W-1:0] row_q, row_nx;
  logic [HALF_W-1:0] col_q, col_nx;

  always_comb begin
    row_nx = row_en ? bus : row_q;
    col_nx = col_en ? bus : col_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_nx;
      col_q <= col_nx;
    end
  end

  assign addr = {row_q, col_q};

endmodule

// File: rtl/dsb_ctrl.sv
module dsb_ctrl
  import dsb_pkg::*;
#(
  parameter int SETTLE_CYC = 2,
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ras_s,
  input  logic      cas_hi_s,
  input  logic      cas_lo_s,
  input  logic      we_s,
  output logic      row_en,
  output logic      col_en,
  output sram_ctl_t ctl
);

  cyc_state_e state_q, state_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic wr_q, wr_nx;
  logic ras_d_q, cas_any_d_q;
  logic cas_any, ras_fall, cas_fall;
  sram_ctl_t ctl_q, ctl_nx;

  assign cas_any  = ~cas_hi_s | ~cas_lo_s;
  assign ras_fall = ras_d_q & ~ras_s;
  assign cas_fall = cas_any & ~cas_any_d_q;

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    wr_nx    = wr_q;
    row_en   = 1'b0;
    col_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ras_fall) begin
          state_nx = ST_ROW;
          row_en   = 1'b1;
          wr_nx    = ~we_s;
        end
      end
      ST_ROW: begin
        if (ras_s) begin
          state_nx = ST_IDLE;
        end else if (cas_fall) begin
          col_en   = 1'b1;
          cnt_nx   = '0;
          state_nx = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (ras_s) begin
          state_nx = ST_IDLE;
        end else if (cnt_q == CW'(SETTLE_CYC - 1)) begin
          state_nx = ST_ACTIVE;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (ras_s) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
    if (state_nx == ST_IDLE) wr_nx = 1'b0;
  end

  always_comb begin
    ctl_nx.ce = (state_nx == ST_ACTIVE);
    ctl_nx.oe = ctl_nx.ce & ~wr_nx;
    ctl_nx.we = ctl_nx.ce & wr_nx;
    ctl_nx.ub = ctl_nx.ce & ~cas_hi_s;
    ctl_nx.lb = ctl_nx.ce & ~cas_lo_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      wr_q        <= 1'b0;
      ras_d_q     <= 1'b1;
      cas_any_d_q <= 1'b0;
      ctl_q       <= '0;
    end else begin
      state_q     <= state_nx;
      cnt_q       <= cnt_nx;
      wr_q        <= wr_nx;
      ras_d_q     <= ras_s;
      cas_any_d_q <= cas_any;
      ctl_q       <= ctl_nx;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge
  import dsb_pkg::*;
#(
  parameter int HALF_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 2,
  localparam int SRAM_AW    = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ras_n,
  input  logic               cas_hi_n,
  input  logic               cas_lo_n,
  input  logic               we_n,
  input  logic [HALF_W-1:0]  mux_addr,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_ce_n,
  output logic               sram_oe_n,
  output logic               sram_we_n,
  output logic               sram_ub_n,
  output logic               sram_lb_n
);

  logic       rst_sync_n;
  logic [3:0] strobe_s;
  logic [HALF_W-1:0] bus_s;
  logic       row_en, col_en;
  sram_ctl_t  ctl;

  dsb_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  dsb_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_strobe_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({ras_n, cas_hi_n, cas_lo_n, we_n}),
    .q(strobe_s)
  );

  dsb_sync #(.WIDTH(HALF_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(mux_addr), .q(bus_s)
  );

  dsb_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .ras_s(strobe_s[3]), .cas_hi_s(strobe_s[2]),
    .cas_lo_s(strobe_s[1]), .we_s(strobe_s[0]),
    .row_en(row_en), .col_en(col_en), .ctl(ctl)
  );

  dsb_addr_latch #(.HALF_W(HALF_W)) u_addr (
    .clk(clk), .rst_n(rst_sync_n),
    .row_en(row_en), .col_en(col_en),
    .bus(bus_s), .addr(sram_addr)
  );

  assign sram_ce_n = ~ctl.ce;
  assign sram_oe_n = ~ctl.oe;
  assign sram_we_n = ~ctl.we;
  assign sram_ub_n = ~ctl.ub;
  assign sram_lb_n = ~ctl.lb;

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
  parameter int SRAM_AW = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ras_n,
  input logic               cas_hi_n,
  input logic               cas_lo_n,
  input logic               sram_ce_n,
  input logic               sram_oe_n,
  input logic               sram_we_n,
  input logic               sram_ub_n,
  input logic               sram_lb_n,
  input logic [SRAM_AW-1:0] sram_addr
);

  logic [1:0] ras_hi_cnt;
  logic       seen_cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_hi_cnt <= 2'd0;
      seen_cas   <= 1'b0;
    end else begin
      if (ras_n) ras_hi_cnt <= (ras_hi_cnt == 2'd3) ? 2'd3 : ras_hi_cnt + 2'd1;
      else       ras_hi_cnt <= 2'd0;
      if (!cas_hi_n || !cas_lo_n) seen_cas <= 1'b1;
      else if (ras_hi_cnt == 2'd3) seen_cas <= 1'b0;
    end
  end

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n)); // R8

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_ce_n); // R7

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R8

  AST_BYTE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ub_n || !sram_lb_n) |-> !sram_ce_n); // R6

  AST_RAS_HIGH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_hi_cnt == 2'd3) |-> (sram_ce_n && sram_oe_n && sram_we_n && sram_ub_n && sram_lb_n)); // R9

  AST_NO_CE_WITHOUT_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> seen_cas); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R3

endmodule

bind dram_sram_bridge dsb_checker #(.SRAM_AW(SRAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n),
  .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n),
  .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
  .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_addr(sram_addr)
);

// File: tb/dram_sram_bridge_bench.sv
module dram_sram_bridge_bench;

  logic        clk;
  logic        rst_n;
  logic        ras_n, cas_hi_n, cas_lo_n, we_n;
  logic [8:0]  mux_addr;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 0;

  dram_sram_bridge u_dram_sram_bridge (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_hi_n(cas_hi_n),
    .cas_lo_n(cas_lo_n), .we_n(we_n), .mux_addr(mux_addr),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ctl5();
    return {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bm: 0 word, 1 upper byte only, 2 lower byte only
  task automatic access(input int row, input int col, input bit wr, input int bm);
    bit hi, lo;
    hi = (bm != 2);
    lo = (bm != 1);
    mux_addr = 9'(row);
    we_n = !wr;
    step(1);
    ras_n = 1'b0;
    step(3);
    mux_addr = 9'(col);
    step(2);
    cas_hi_n = !hi;
    cas_lo_n = !lo;
    step(4);
    chk("R5 ce before settle done", int'(sram_ce_n), 1);
    step(1);
    chk("R5 ce after settle", int'(sram_ce_n), 0);
    chk("R2 row half", int'(sram_addr[17:9]), row);
    chk("R3 column half", int'(sram_addr[8:0]), col);
    chk("R7 oe", int'(sram_oe_n), wr ? 1 : 0);
    chk("R8 we", int'(sram_we_n), wr ? 0 : 1);
    chk("R6 ub", int'(sram_ub_n), hi ? 0 : 1);
    chk("R6 lb", int'(sram_lb_n), lo ? 0 : 1);
    mux_addr = ~9'(col);
    step(3);
    chk("R3 bus change ignored", int'(sram_addr), (row << 9) | col);
    ras_n = 1'b1;
    cas_hi_n = 1'b1;
    cas_lo_n = 1'b1;
    step(3);
    chk("R9 release", ctl5(), 31);
    we_n = 1'b1;
    step(5);
  endtask

  task automatic refresh(input int row);
    mux_addr = 9'(row);
    step(1);
    ras_n = 1'b0;
    for (int i = 0; i < 17; i++) begin
      step(1);
      chk("R4 refresh idle", ctl5(), 31);
    end
    ras_n = 1'b1;
    step(8);
    chk("R4 refresh end", ctl5(), 31);
  endtask

  task automatic stray_cas();
    cas_hi_n = 1'b0;
    cas_lo_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R10 cas without ras", ctl5(), 31);
    end
    cas_hi_n = 1'b1;
    cas_lo_n = 1'b1;
    step(6);
  endtask

  initial begin
    rst_n = 1'b0;
    ras_n = 1'b1;
    cas_hi_n = 1'b1;
    cas_lo_n = 1'b1;
    we_n = 1'b1;
    mux_addr = '0;
    step(3);
    chk("R1 controls at reset", ctl5(), 31);
    chk("R1 address at reset", int'(sram_addr), 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 controls after release", ctl5(), 31);
    for (int r = 0; r < 8; r++) begin
      int row, col;
      row = (r * 73 + 5) % 512;
      col = (r * 151 + 300) % 512;
      refresh((row + 1) % 512);
      for (int m = 0; m < 6; m++) begin
        access(row, col, m[0], m / 2);
      end
      stray_cas();
    end
    access(511, 0, 1'b1, 0);
    access(0, 511, 1'b0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule